// File: doc/BRIEF.md
# Duplicated Adder with Two-Rail Comparison Checker

This block guards a small combinational function, a WIDTH-bit adder with carry-in and carry-out, by building it twice from separate gates and comparing the two results bit by bit. The function output seen by the rest of the chip comes from the first copy only. The second copy exists only to be compared against the first.

Each result bit of the two copies forms one two-rail leaf pair. These pairs are merged by a tree of two-input two-rail cells into one error pair. When both rails of the final pair differ, the copies agree. When both rails are equal, an error has occurred. The checker is built this way, not as an OR of mismatch bits, so a single flipped wire inside the checker also produces an invalid code and does not go unnoticed.

A simulation-only fault port flips chosen output bits of either copy, or chosen rails inside the checker. This lets a bench show that every single fault is flagged and that the result is never wrong unless the flag is raised.

Top module: `dual_compute_guard`

## Requirements
- R1: With no fault selected, `{carry_out, sum_out}` equals `op_x + op_y + carry_in`, where `carry_out` is the bit above the WIDTH sum bits.
- R2: The primary result is taken from the first copy. With `fault_site` = 1, result bit i (bit WIDTH is `carry_out`) is the correct bit i XOR `fault_mask[i]`.
- R3: With `fault_site` = 0, `err_pair` is 2'b01 or 2'b10 for every input.
- R4: Flipping any single output bit of either copy (`fault_site` = 1 or 2, one bit set among `fault_mask[WIDTH:0]`) drives `err_pair` to 2'b00 or 2'b11 for every input.
- R5: Flipping any single checker rail (`fault_site` = 3, one bit of `fault_mask` set) drives `err_pair` to 2'b00 or 2'b11 for every input. The checker rails are numbered as follows. Mask bit 2n+r flips rail r of node n, with r=1 the high rail. Nodes 0..WIDTH are the leaf pairs of result bits 0..WIDTH. Merge cell k takes nodes 2k and 2k+1 and drives node WIDTH+1+k. The last node is `err_pair`.
- R6: Fault-secure output: with `fault_site` = 2 or 3, the result is the correct sum for every input and every mask.
- R7: The `fault_site` encoding is 0 = none, 1 = copy A outputs, 2 = copy B outputs, 3 = checker rails. With site 0 the mask has no effect. With site 1 or 2, mask bits above bit WIDTH have no effect.
- R8: Any nonzero set of flipped bits on one copy's outputs, however many bits are flipped, gives an invalid `err_pair`.
- R9: Leaf pair n is (copy A bit n, inverted copy B bit n). A merge cell with inputs (p1,p0) and (q1,q0) drives z1 = p1q1 + p0q0 and z0 = p1q0 + p0q1. Two valid inputs give a valid output, and an invalid input gives an invalid output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_x | input | WIDTH | First addend |
| op_y | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| fault_site | input | 2 | Fault target: 0 none, 1 copy A, 2 copy B, 3 checker |
| fault_mask | input | 2*(2*(WIDTH+1)-1) | Bits to flip at the chosen site |
| sum_out | output | WIDTH | Sum from copy A |
| carry_out | output | 1 | Carry out from copy A |
| err_pair | output | 2 | Two-rail error code: 01/10 = agree, 00/11 = error |

## Verification
The bench builds the block with WIDTH = 8. This gives nine result bits, nine leaf pairs, eight merge cells and 34 checker rails. At this size every single-bit fault at every site can be injected one at a time, each against several operand patterns, including full carry propagation. The same size also makes exhaustive sweeps of mask bits cheap, covering both the ignored-mask cases and multi-bit copy faults.

// File: rtl/dcg_pkg.sv
package dcg_pkg;

    typedef enum logic [1:0] {
        SITE_NONE    = 2'd0,
        SITE_COPY_A  = 2'd1,
        SITE_COPY_B  = 2'd2,
        SITE_CHECKER = 2'd3
    } fault_site_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } rail_pair_t;

    function automatic logic pair_ok(input rail_pair_t p);
        return p.hi ^ p.lo;
    endfunction

    function automatic rail_pair_t pair_merge(input rail_pair_t p, input rail_pair_t q);
        rail_pair_t z;
        z.hi = (p.hi & q.hi) | (p.lo & q.lo);
        z.lo = (p.hi & q.lo) | (p.lo & q.hi);
        return z;
    endfunction

endpackage

// File: rtl/adder_replica.sv
module adder_replica
    #(parameter int WIDTH = 8)
    (
        input  logic [WIDTH-1:0] op_x,
        input  logic [WIDTH-1:0] op_y,
        input  logic             c_in,
        output logic [WIDTH:0]   result
    );

    logic [WIDTH:0] carry;

    assign carry[0] = c_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic prop;
        logic gen;
        assign prop       = op_x[i] ^ op_y[i];
        assign gen        = op_x[i] & op_y[i];
        assign result[i]  = prop ^ carry[i];
        assign carry[i+1] = gen | (prop & carry[i]);
    end

    assign result[WIDTH] = carry[WIDTH];

    always_comb begin
        assert_core_sum_R1: assert (result == ({1'b0, op_x} + {1'b0, op_y} + {{WIDTH{1'b0}}, c_in}));
    end

endmodule

// File: rtl/rail_merge_cell.sv
module rail_merge_cell
    import dcg_pkg::*;
    (
        input  rail_pair_t in_p,
        input  rail_pair_t in_q,
        output rail_pair_t out_z
    );

    assign out_z = pair_merge(in_p, in_q);

    always_comb begin
        if (pair_ok(in_p) && pair_ok(in_q)) begin
            assert_cell_valid_R9: assert (pair_ok(out_z));
        end
        if (!pair_ok(in_p) || !pair_ok(in_q)) begin
            assert_cell_propagate_R9: assert (!pair_ok(out_z));
        end
    end

endmodule

// File: rtl/rail_reduce_tree.sv
module rail_reduce_tree
    import dcg_pkg::*;
    #(
        parameter int LEAVES = 9,
        localparam int NODES = 2 * LEAVES - 1,
        localparam int NET_W = 2 * NODES
    )
    (
        input  logic [2*LEAVES-1:0] leaf_rails,
        input  logic [NET_W-1:0]    net_flip,
        output rail_pair_t          root
    );

    rail_pair_t node_raw [NODES];
    rail_pair_t node_f   [NODES];

    for (genvar n = 0; n < LEAVES; n++) begin : g_leaf
        assign node_raw[n] = rail_pair_t'(leaf_rails[2*n +: 2]);
    end

    for (genvar k = 0; k < LEAVES - 1; k++) begin : g_cell
        rail_merge_cell u_cell (
            .in_p  (node_f[2*k]),
            .in_q  (node_f[2*k+1]),
            .out_z (node_raw[LEAVES+k])
        );
    end

    for (genvar n = 0; n < NODES; n++) begin : g_flip
        assign node_f[n] = rail_pair_t'(node_raw[n] ^ net_flip[2*n +: 2]);
    end

    assign root = node_f[NODES-1];

endmodule

// File: rtl/dual_compute_guard.sv
module dual_compute_guard
    import dcg_pkg::*;
    #(
        parameter int WIDTH = 8,
        localparam int OUT_W = WIDTH + 1,
        localparam int NET_W = 2 * (2 * OUT_W - 1)
    )
    (
        input  logic [WIDTH-1:0] op_x,
        input  logic [WIDTH-1:0] op_y,
        input  logic             carry_in,
        input  logic [1:0]       fault_site,
        input  logic [NET_W-1:0] fault_mask,
        output logic [WIDTH-1:0] sum_out,
        output logic             carry_out,
        output logic [1:0]       err_pair
    );

    fault_site_e site;
    logic [OUT_W-1:0]  raw_a;
    logic [OUT_W-1:0]  raw_b;
    logic [OUT_W-1:0]  flip_a;
    logic [OUT_W-1:0]  flip_b;
    logic [NET_W-1:0]  flip_chk;
    logic [OUT_W-1:0]  res_a;
    logic [OUT_W-1:0]  res_b;
    logic [2*OUT_W-1:0] leaves;
    rail_pair_t         root;

    assign site = fault_site_e'(fault_site);

    adder_replica #(.WIDTH(WIDTH)) u_copy_a (
        .op_x   (op_x),
        .op_y   (op_y),
        .c_in   (carry_in),
        .result (raw_a)
    );

    adder_replica #(.WIDTH(WIDTH)) u_copy_b (
        .op_x   (op_x),
        .op_y   (op_y),
        .c_in   (carry_in),
        .result (raw_b)
    );

    assign flip_a   = (site == SITE_COPY_A)  ? fault_mask[OUT_W-1:0] : '0;
    assign flip_b   = (site == SITE_COPY_B)  ? fault_mask[OUT_W-1:0] : '0;
    assign flip_chk = (site == SITE_CHECKER) ? fault_mask            : '0;

    assign res_a = raw_a ^ flip_a;
    assign res_b = raw_b ^ flip_b;

    for (genvar n = 0; n < OUT_W; n++) begin : g_leaf
        assign leaves[2*n+1] = res_a[n];
        assign leaves[2*n]   = ~res_b[n];
    end

    rail_reduce_tree #(.LEAVES(OUT_W)) u_tree (
        .leaf_rails (leaves),
        .net_flip   (flip_chk),
        .root       (root)
    );

    assign sum_out   = res_a[WIDTH-1:0];
    assign carry_out = res_a[WIDTH];
    assign err_pair  = {root.hi, root.lo};

    always_comb begin
        if (site == SITE_NONE) begin
            assert_clean_valid_R3: assert (err_pair[1] ^ err_pair[0]);
        end
        if (site != SITE_COPY_A) begin
            assert_output_secure_R6: assert ({carry_out, sum_out} == raw_b);
        end
        if (res_a != res_b && site != SITE_CHECKER) begin
            assert_mismatch_flagged_R8: assert (err_pair[1] == err_pair[0]);
        end
    end

endmodule

// File: tb/test_dual_compute_guard.sv
module test_dual_compute_guard;

    localparam int CLK_PERIOD = 10;
    localparam int WIDTH = 8;
    localparam int OUT_W = WIDTH + 1;
    localparam int NET_W = 2 * (2 * OUT_W - 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [WIDTH-1:0] op_x = '0;
    logic [WIDTH-1:0] op_y = '0;
    logic             carry_in = 1'b0;
    logic [1:0]       fault_site = 2'd0;
    logic [NET_W-1:0] fault_mask = '0;
    logic [WIDTH-1:0] sum_out;
    logic             carry_out;
    logic [1:0]       err_pair;

    int checks = 0;
    int errors = 0;
    logic [31:0] seed = 32'h1234_abcd;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_compute_guard #(.WIDTH(WIDTH)) i_dual_compute_guard (
        .op_x       (op_x),
        .op_y       (op_y),
        .carry_in   (carry_in),
        .fault_site (fault_site),
        .fault_mask (fault_mask),
        .sum_out    (sum_out),
        .carry_out  (carry_out),
        .err_pair   (err_pair)
    );

    task automatic summary_and_end();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    function automatic logic [WIDTH-1:0] next_rand();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed[23:16];
    endfunction

    // Reference model: behavioural sum plus expected code validity.
    task automatic run_vec(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y,
                           input logic c, input logic [1:0] site,
                           input logic [NET_W-1:0] mask, input logic exp_valid,
                           input string req);
        logic [OUT_W-1:0] exp_res;
        logic [OUT_W-1:0] got;
        @(posedge clk);
        op_x = x; op_y = y; carry_in = c; fault_site = site; fault_mask = mask;
        @(negedge clk);
        exp_res = OUT_W'(int'(x) + int'(y) + int'(c));
        if (site == 2'd1) exp_res = exp_res ^ mask[OUT_W-1:0];
        got = {carry_out, sum_out};
        checks++;
        if (got !== exp_res) begin
            errors++;
            $display("FAIL %s result: actual=%h expected=%h (x=%h y=%h c=%b site=%0d)",
                     req, got, exp_res, x, y, c, site);
        end
        checks++;
        if ((err_pair[1] ^ err_pair[0]) !== exp_valid) begin
            errors++;
            $display("FAIL %s err_pair: actual=%b expected %s (x=%h y=%h site=%0d mask=%h)",
                     req, err_pair, exp_valid ? "01/10" : "00/11", x, y, site, mask);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary_and_end();
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Initial state: zero operands, no fault (R1, R3)
        checks++;
        if ({carry_out, sum_out} !== '0 || !(err_pair[1] ^ err_pair[0])) begin
            errors++;
            $display("FAIL R3 initial: actual=%h/%b expected=0/valid", {carry_out, sum_out}, err_pair);
        end

        // R1 and R3: directed corner operands
        run_vec(8'h00, 8'h00, 1'b0, 2'd0, '0, 1'b1, "R1");
        run_vec(8'hFF, 8'hFF, 1'b1, 2'd0, '0, 1'b1, "R1");
        run_vec(8'hFF, 8'h00, 1'b1, 2'd0, '0, 1'b1, "R1");
        run_vec(8'h80, 8'h80, 1'b0, 2'd0, '0, 1'b1, "R3");
        run_vec(8'h55, 8'hAA, 1'b0, 2'd0, '0, 1'b1, "R3");
        run_vec(8'h0F, 8'hF1, 1'b0, 2'd0, '0, 1'b1, "R1");

        // R1 and R3: pseudo-random operands
        for (int i = 0; i < 150; i++) begin
            logic [WIDTH-1:0] rx;
            logic [WIDTH-1:0] ry;
            rx = next_rand();
            ry = next_rand();
            run_vec(rx, ry, rx[0] ^ ry[3], 2'd0, '0, 1'b1, "R1");
        end

        // R2 and R4: single flips on copy A outputs
        for (int b = 0; b < OUT_W; b++) begin
            for (int v = 0; v < 4; v++) begin
                run_vec(next_rand(), next_rand(), v[0], 2'd1, NET_W'(1) << b, 1'b0, "R2/R4");
            end
        end

        // R4 and R6: single flips on copy B outputs
        for (int b = 0; b < OUT_W; b++) begin
            for (int v = 0; v < 4; v++) begin
                run_vec(next_rand(), next_rand(), v[1], 2'd2, NET_W'(1) << b, 1'b0, "R4/R6");
            end
        end

        // R5 and R6: single flips on every checker rail
        for (int b = 0; b < NET_W; b++) begin
            for (int v = 0; v < 4; v++) begin
                run_vec(next_rand(), next_rand(), v[0], 2'd3, NET_W'(1) << b, 1'b0, "R5/R6");
            end
        end
        run_vec(8'hFF, 8'hFF, 1'b1, 2'd3, NET_W'(1) << (NET_W - 1), 1'b0, "R5");
        run_vec(8'h00, 8'h00, 1'b0, 2'd3, NET_W'(1), 1'b0, "R5");

        // R7: site 0 ignores the whole mask
        run_vec(8'h3C, 8'h4B, 1'b1, 2'd0, '1, 1'b1, "R7");
        run_vec(8'hFF, 8'h01, 1'b0, 2'd0, NET_W'(1) << 5, 1'b1, "R7");
        // R7: copy sites ignore mask bits above bit WIDTH
        for (int b = OUT_W; b < NET_W; b++) begin
            run_vec(next_rand(), next_rand(), 1'b1, 2'd1, NET_W'(1) << b, 1'b1, "R7");
            run_vec(next_rand(), next_rand(), 1'b0, 2'd2, NET_W'(1) << b, 1'b1, "R7");
        end

        // R8: multi-bit faults on one copy
        run_vec(8'h12, 8'h34, 1'b0, 2'd1, NET_W'(9'h1FF), 1'b0, "R8");
        run_vec(8'hF0, 8'h0F, 1'b1, 2'd2, NET_W'(9'h003), 1'b0, "R8");
        run_vec(8'hAA, 8'h55, 1'b0, 2'd2, NET_W'(9'h155), 1'b0, "R8");
        run_vec(8'h77, 8'h88, 1'b1, 2'd1, NET_W'(9'h0C0), 1'b0, "R8");
        for (int m = 1; m < 64; m++) begin
            run_vec(next_rand(), next_rand(), m[0], m[1] ? 2'd1 : 2'd2, NET_W'(m * 7) & NET_W'(9'h1FF) | NET_W'(1), 1'b0, "R8");
        end

        // R9: clean pass after faults, leaf/cell coding yields valid code
        run_vec(8'hC3, 8'h3C, 1'b1, 2'd0, '0, 1'b1, "R9");

        summary_and_end();
    end

endmodule